// File: doc/BRIEF.md
# Gated Frequency and Period Measurement Counter

This block measures a signal in one of two ways. In frequency mode it counts the rising edges of a chosen input over a gate window of 1, 4, 16 or 64 ms. In period mode it counts reference pulses, which are system clock cycles, over exactly one cycle of a slow input. The block has its own 1 ms timebase, made by dividing the system clock by a parameter. Every gate window starts on a tick of that timebase.

A host starts a measurement with a one-cycle start pulse. The gate time and the input selection are captured on that pulse. The host then polls the busy flag. The count is valid once busy and the overflow flag both read 0. The three measured inputs are asynchronous. Each one passes through a synchronizer and an edge detector in the system clock domain, so an input must toggle at less than half the system clock rate.

Top module: `gate_meas_counter`

## Requirements
- R1: In frequency mode the count equals the number of rising edges of the selected input seen during the gate window. The count never falls during a measurement, except when a start clears it. The count is CNT_W bits wide, and CNT_W defaults to 20.
- R2: The gate time comes from `gate_sel`, where bit 0 holds the low select bit and bit 1 the high select bit. The values 0, 1, 2 and 3 select 1 ms, 4 ms, 16 ms and 64 ms. One ms is CLK_PER_MS clock cycles.
- R3: `over` is set when the count would reach 2^CNT_W. `result` then holds at all ones. Both stay that way until the next start.
- R4: A cycle with `start` high clears `result` and `over` and sets `busy` on the next edge. This holds even when a measurement is already running, in which case the measurement restarts with the newly captured settings.
- R5: While `start` stays low, a finished result, `busy` and `over` remain unchanged, whatever the measured inputs do.
- R6: `busy` is 1 from the edge after the start pulse until the window closes. It reads 0 once the count is final.
- R7: The window opens on the first 1 ms tick after the start edge. If a tick falls in the same cycle as the start, the window waits for the following tick. In frequency mode, `busy` therefore lasts for the remaining part of the current millisecond plus the gate time.
- R8: Setting only `src_sel[0]`, the slow input, selects period mode. In this mode `result` equals the number of clock cycles between two successive rising edges of `lf_in`.
- R9: Input priority is `src_sel[1]` (IF1), then `src_sel[2]` (IF2), then `src_sel[0]` (slow input). If no bit is set, the block runs a frequency window that counts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System and reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle measurement start |
| gate_sel | input | 2 | Gate time select, low bit at index 0 |
| src_sel | input | 3 | Input select: [0] slow input, [1] IF1, [2] IF2 |
| lf_in | input | 1 | Slow input measured in period mode |
| if1_in | input | 1 | First frequency input |
| if2_in | input | 1 | Second frequency input |
| result | output | CNT_W | Measured count |
| busy | output | 1 | Measurement in progress |
| over | output | 1 | Count overflowed, sticky until start |

## Verification
A start pulse and a 1 ms timebase tick can occur in the same clock cycle. The start must win, and the window must wait for the next tick. The bench keeps its own count of clock edges since reset, which lets it place a start exactly on a tick edge and also at an offset inside the millisecond. It judges each case by the length of `busy`, expecting one full millisecond plus the gate time in the first case and the remainder of the millisecond plus the gate time in the second. It also checks that the edge count is unchanged. Restarting during a running gate and clearing a sticky overflow are provoked in the same way and checked at the ports.

// File: rtl/gmc_pkg.sv
package gmc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ARM  = 3'd1,
    ST_GATE = 3'd2,
    ST_SEEK = 3'd3,
    ST_SPAN = 3'd4
  } gmc_state_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_IF1  = 2'd1,
    SRC_IF2  = 2'd2,
    SRC_LF   = 2'd3
  } gmc_src_e;

  localparam int MS_W = 7;

  // gate length in timebase ticks: 4 to the power of the select value
  function automatic logic [MS_W-1:0] gate_ms_of(input logic [1:0] sel);
    return MS_W'(1) << (2 * sel);
  endfunction

  // IF1 first, then IF2, then the slow input
  function automatic gmc_src_e src_pick(input logic [2:0] sel);
    if (sel[1])      return SRC_IF1;
    else if (sel[2]) return SRC_IF2;
    else if (sel[0]) return SRC_LF;
    else             return SRC_NONE;
  endfunction

endpackage

// File: rtl/gmc_tick.sv
module gmc_tick #(
  parameter int DIV = 50000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + W'(1);
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/gmc_edge_sync.sv
module gmc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/gmc_ctrl.sv
module gmc_ctrl
  import gmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] gate_sel,
  input  logic [2:0] src_sel,
  input  logic       tick,
  input  logic       sel_rise,
  output gmc_src_e   src_q,
  output logic       busy,
  output logic       count_inc,
  output logic       armed,
  output logic       per_mode
);
  gmc_state_e      st;
  logic [MS_W-1:0] ms_left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      ms_left <= '0;
      src_q   <= SRC_NONE;
    end else if (start) begin
      st      <= ST_ARM;
      ms_left <= gate_ms_of(gate_sel);
      src_q   <= src_pick(src_sel);
    end else begin
      case (st)
        ST_ARM:  if (tick) st <= (src_q == SRC_LF) ? ST_SEEK : ST_GATE;
        ST_GATE: if (tick) begin
                   if (ms_left == MS_W'(1)) st <= ST_IDLE;
                   else                     ms_left <= ms_left - MS_W'(1);
                 end
        ST_SEEK: if (sel_rise) st <= ST_SPAN;
        ST_SPAN: if (sel_rise) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (st != ST_IDLE);
  assign armed     = (st == ST_ARM);
  assign per_mode  = (src_q == SRC_LF);
  assign count_inc = ((st == ST_GATE) && sel_rise) || (st == ST_SPAN);
endmodule

// File: rtl/gmc_accum.sv
module gmc_accum #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         inc,
  output logic [W-1:0] count,
  output logic         over
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      count <= '0;
      over  <= 1'b0;
    end else if (inc) begin
      if (count == TOP) over  <= 1'b1;
      else              count <= count + W'(1);
    end
  end
endmodule

// File: rtl/gate_meas_counter.sv
module gate_meas_counter
  import gmc_pkg::*;
#(
  parameter int CNT_W      = 20,
  parameter int CLK_PER_MS = 50000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       gate_sel,
  input  logic [2:0]       src_sel,
  input  logic             lf_in,
  input  logic             if1_in,
  input  logic             if2_in,
  output logic [CNT_W-1:0] result,
  output logic             busy,
  output logic             over
);
  localparam int N_IN = 3;

  logic            tick_w;
  logic [N_IN-1:0] raw_in;
  logic [N_IN-1:0] rise_w;
  logic            sel_rise;
  logic            count_inc;
  logic            armed_w;
  logic            per_mode_w;
  gmc_src_e        src_q;

  assign raw_in = {if2_in, if1_in, lf_in};

  gmc_tick #(.DIV(CLK_PER_MS)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick_w)
  );

  for (genvar i = 0; i < N_IN; i++) begin : g_sync
    gmc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(raw_in[i]), .rise(rise_w[i])
    );
  end

  always_comb begin
    case (src_q)
      SRC_IF1: sel_rise = rise_w[1];
      SRC_IF2: sel_rise = rise_w[2];
      SRC_LF:  sel_rise = rise_w[0];
      default: sel_rise = 1'b0;
    endcase
  end

  gmc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .gate_sel(gate_sel),
    .src_sel(src_sel), .tick(tick_w), .sel_rise(sel_rise),
    .src_q(src_q), .busy(busy), .count_inc(count_inc),
    .armed(armed_w), .per_mode(per_mode_w)
  );

  gmc_accum #(.W(CNT_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(start), .inc(count_inc),
    .count(result), .over(over)
  );
endmodule

// File: rtl/gmc_checker.sv
module gmc_checker #(
  parameter int W = 20
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         over,
  input logic [W-1:0] result,
  input logic         tick,
  input logic         armed,
  input logic         per_mode
);
  assert_count_monotonic_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (result >= $past(result)));

  assert_over_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (over && !start) |=> over);

  assert_over_saturates_R3: assert property (@(posedge clk) disable iff (!rst_n)
    over |-> (result == '1));

  assert_start_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !over && result == '0));

  assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> (!busy && $stable(result) && $stable(over)));

  assert_gate_closes_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !per_mode) |-> $past(tick));

  assert_gate_opens_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(armed) |-> $past(tick));
endmodule

bind gate_meas_counter gmc_checker #(.W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .over(over),
  .result(result), .tick(tick_w), .armed(armed_w), .per_mode(per_mode_w)
);

// File: tb/gate_meas_counter_test.sv
`timescale 1ns/1ps
module gate_meas_counter_test;
  localparam int M  = 12;
  localparam int W  = 8;
  localparam int NV = 12;

  typedef struct packed {
    int g;
    int src;
    int p1;
    int p2;
    int q;
    int res;
    int ovr;
  } vec_t;

  // gate cycles: g0=12, g1=48, g2=192, g3=768 ; 8-bit count saturates at 255
  localparam vec_t TAB [NV] = '{
    '{0, 2, 2, 3, 10,   6, 0},  // R1 IF1, 12/2
    '{1, 4, 2, 3, 10,  16, 0},  // R2 IF2, 48/3
    '{2, 2, 4, 2, 10,  48, 0},  // R2 IF1, 192/4
    '{3, 2, 3, 2, 10, 255, 1},  // R3 768/3 = 256 reaches 2^8
    '{3, 4, 2, 4, 10, 192, 0},  // R2 IF2, 768/4
    '{2, 6, 6, 2, 10,  32, 0},  // R9 IF1 over IF2
    '{1, 0, 2, 2, 10,   0, 0},  // R9 nothing selected
    '{0, 3, 3, 2, 10,   4, 0},  // R9 IF1 over slow input
    '{0, 1, 2, 2, 10,  10, 0},  // R8 period 10
    '{2, 1, 2, 2, 37,  37, 0},  // R8 period 37
    '{0, 5, 2, 6, 10,   2, 0},  // R9 IF2 over slow input
    '{1, 1, 2, 2, 300, 255, 1}  // R3 period overflow
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] gsel = '0;
  logic [2:0] ssel = '0;
  logic lf = 1'b0, i1 = 1'b0, i2 = 1'b0;
  logic [W-1:0] result;
  logic busy, over;

  int k = 0;
  int s_idx = 0;
  int p1 = 2, p2 = 2, q = 10;
  int ph1 = 0, ph2 = 0, phq = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gate_meas_counter #(.CNT_W(W), .CLK_PER_MS(M)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .gate_sel(gsel), .src_sel(ssel),
    .lf_in(lf), .if1_in(i1), .if2_in(i2),
    .result(result), .busy(busy), .over(over)
  );

  initial forever begin
    @(posedge clk);
    if (rst_n) k++;
  end

  initial forever begin
    @(negedge clk);
    ph1 = (ph1 + 1) % p1; i1 = (ph1 < p1 / 2);
    ph2 = (ph2 + 1) % p2; i2 = (ph2 < p2 / 2);
    phq = (phq + 1) % q;  lf = (phq < q / 2);
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic launch(input int g, input int src, input int align);
    @(negedge clk);
    while (align >= 0 && ((k + 1) % M) != align) @(negedge clk);
    gsel = 2'(g); ssel = 3'(src); start = 1'b1;
    s_idx = k + 1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic await_done(output int len);
    int guard;
    len = 0; guard = 0;
    while (busy && guard < 20000) begin
      len++; guard++;
      @(negedge clk);
    end
  endtask

  function automatic int exp_len(input int s, input int g);
    return ((s / M + 1) * M) - s + (1 << (2 * g)) * M;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    report();
  end

  initial begin
    int len;
    int hold;
    repeat (4) @(negedge clk);
    check("R4 reset result", int'(result), 0);
    check("R6 reset busy", int'(busy), 0);
    check("R3 reset over", int'(over), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      p1 = TAB[v].p1; p2 = TAB[v].p2; q = TAB[v].q;
      repeat (2 * q + 8) @(negedge clk);
      launch(TAB[v].g, TAB[v].src, -1);
      await_done(len);
      check($sformatf("R1/R8/R9 result vec%0d", v), int'(result), TAB[v].res);
      check($sformatf("R3 over vec%0d", v), int'(over), TAB[v].ovr);
      if ((TAB[v].src & 6) != 0 || TAB[v].src == 0)
        check($sformatf("R2/R6 busy length vec%0d", v), len, exp_len(s_idx, TAB[v].g));
      if (v == 3) begin
        repeat (40) @(negedge clk);
        check("R3 over sticky", int'(over), 1);
        check("R3 result saturated", int'(result), 255);
      end
    end

    // R5: idle result untouched while inputs keep toggling
    hold = int'(result);
    repeat (60) @(negedge clk);
    check("R5 result holds", int'(result), hold);
    check("R5 busy stays low", int'(busy), 0);
    check("R5 over holds", int'(over), 1);

    // R4: start clears the sticky overflow
    p1 = 2;
    repeat (8) @(negedge clk);
    launch(0, 2, -1);
    check("R4 result cleared", int'(result), 0);
    check("R4 over cleared", int'(over), 0);
    check("R4 busy set", int'(busy), 1);
    await_done(len);
    check("R1 count after clear", int'(result), 6);

    // R7: start in the same cycle as a tick waits a whole ms
    p1 = 4;
    repeat (8) @(negedge clk);
    launch(1, 2, 0);
    await_done(len);
    check("R7 busy length start on tick", len, M + 48);
    check("R7 count start on tick", int'(result), 12);
    launch(1, 2, 5);
    await_done(len);
    check("R7 busy length mid ms", len, (M - 5) + 48);
    check("R7 count mid ms", int'(result), 12);

    // R4: restart during a running gate
    launch(2, 2, -1);
    repeat (60) @(negedge clk);
    check("R6 busy mid gate", int'(busy), 1);
    launch(0, 2, 3);
    check("R4 restart clears", int'(result), 0);
    await_done(len);
    check("R4 restart busy length", len, exp_len(s_idx, 0));
    check("R4 restart result", int'(result), 3);

    report();
  end
endmodule